// File: doc/BRIEF.md
# Core Voltage Target Ramp and Power Sequencer

This block produces the digital set-point for a multiphase core-voltage regulator. The set-point is held in units of 12.5 mV, where a value of N means N × 12.5 mV. It never jumps. It moves one unit at a time, at a rate set by a parameter counted in microsecond ticks, toward a destination that depends on the power state. The destination is zero when the block is off. During startup it is a boot value. In normal running it is the value decoded from a 7-bit VID input.

The block also sequences the regulator. When the run enable rises, the target climbs to the boot level and the clock-request output is driven high. A fixed delay after the boot level is reached, clock-request is driven low and the target slews on to the VID level. Power-good is gated by two threshold arms, one for the lower threshold and one for the upper. Both arms drop whenever the target is in motion. The lower arm returns a fixed delay after the target settles, and the upper arm returns only in forced-PWM mode.

When the run enable falls, power-good is pulled low and clock-request is released at once. All phases are then activated and the target ramps down to one unit. After that the drivers are disabled and the output discharge switch is closed.

Top module: `vid_ramp_seq`

## Requirements
- R1: A VID code c (7 bits, unsigned) selects a destination of 120 − c units, so code 26 gives 94 (1.1750 V) and code 90 gives 30 (0.3750 V). Codes 120 and above give 0. The boot code uses the same mapping.
- R2: While the synchronous active-low reset is held, the block is in the off state: `target` = 0, `drv_en` = 0, `dischg_on` = 1, `pg_low` = 1, `clkreq_oe` = 0 and `all_phase` = 0.
- R3: `target` changes only on a clock edge where `tick_us` is high. Each change moves it exactly one unit toward the destination, and successive steps are STEP_US ticks apart.
- R4: A rising run enable in the off state starts a ramp from 0 up to the boot destination. During that ramp, clock-request is driven high (`clkreq_oe` = 1, `clkreq_lo` = 0).
- R5: Clock-request is driven low (`clkreq_lo` = 1) CLKEN_DLY_US ticks after `target` reaches the boot destination. From that point the target slews to the VID destination.
- R6: A VID change during a slew redirects the ramp toward the new destination from the current value, reversing direction if needed.
- R7: While `target` differs from its destination, `pg_lo_arm` and `pg_hi_arm` are both 0 and `pg_low` holds its value regardless of the comparator flags.
- R8: In running, `pg_lo_arm` rises PG_DLY_US ticks after `target` reaches the VID destination. `pg_hi_arm` is 1 only when `pg_lo_arm` is 1 and `forced_pwm` is 1.
- R9: Once an arm is set, `pg_low` follows the comparators one edge later: it is 1 if the lower arm is set and `uv_ok` is 0, or if the upper arm is set and `ov_ok` is 0. Otherwise it is 0.
- R10: In the same cycle that the run enable is low, `pg_low` is 1 and `clkreq_oe` is 0. From the next edge, `all_phase` is 1 and the target ramps down toward 1 unit.
- R11: When the shutdown ramp reaches 1 unit or less, `drv_en` falls, `dischg_on` rises and `target` becomes 0. A run enable that returns during the ramp does not cut it short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| run_en | input | 1 | Run enable; low requests shutdown |
| vid_code | input | 7 | Requested voltage code |
| boot_code | input | 7 | Boot voltage code |
| forced_pwm | input | 1 | High while the regulator is in forced-PWM mode |
| uv_ok | input | 1 | Lower power-good comparator: output above lower threshold |
| ov_ok | input | 1 | Upper power-good comparator: output below upper threshold |
| target | output | 7 | Slewed target in 12.5 mV units |
| clkreq_oe | output | 1 | Clock-request pin driven (0 = high impedance) |
| clkreq_lo | output | 1 | Clock-request driven low when driven |
| pg_low | output | 1 | Power-good open-drain pull-down active |
| pg_lo_arm | output | 1 | Lower power-good threshold enabled |
| pg_hi_arm | output | 1 | Upper power-good threshold enabled |
| all_phase | output | 1 | All phases forced active (shutdown ramp) |
| drv_en | output | 1 | High- and low-side driver enable |
| dischg_on | output | 1 | Output discharge switch on |

## Verification
The bench builds the block with STEP_US = 2 and the default delays of 60 and 20 ticks, and it drives a tick every fourth clock. With a two-tick step, the spacing between consecutive target steps differs from the tick spacing, so a slew counter that ignores the divider is caught. The full 60-tick clock-request delay and the 20-tick power-good delay are measured against the tick count. The boot and VID codes are chosen near the low end of the range so that the boot ramp, the VID ramp, a reversed retarget, a clamped code and the shutdown ramp to one unit all fit in a short run.

// File: rtl/vid_ramp_seq.sv
module vid_ramp_seq #(
  parameter int STEP_US      = 1,
  parameter int CLKEN_DLY_US = 60,
  parameter int PG_DLY_US    = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_us,
  input  logic       run_en,
  input  logic [6:0] vid_code,
  input  logic [6:0] boot_code,
  input  logic       forced_pwm,
  input  logic       uv_ok,
  input  logic       ov_ok,
  output logic [6:0] target,
  output logic       clkreq_oe,
  output logic       clkreq_lo,
  output logic       pg_low,
  output logic       pg_lo_arm,
  output logic       pg_hi_arm,
  output logic       all_phase,
  output logic       drv_en,
  output logic       dischg_on
);

  localparam int TMR_MAX = (CLKEN_DLY_US > PG_DLY_US) ? CLKEN_DLY_US : PG_DLY_US;
  localparam int TW      = $clog2(TMR_MAX + 1);
  localparam int SW      = (STEP_US > 1) ? $clog2(STEP_US) : 1;

  typedef enum logic [1:0] {S_OFF, S_BOOT, S_RUN, S_DOWN} st_t;

  st_t           st, st_nx;
  logic [6:0]    target_q, dest;
  logic [SW-1:0] stp_cnt;
  logic [TW-1:0] tmr;
  logic          pg_q, reached, step;

  function automatic logic [6:0] to_units(input logic [6:0] code);
    return (code >= 7'd120) ? 7'd0 : 7'd120 - code;
  endfunction

  always_comb begin
    case (st)
      S_BOOT:  dest = to_units(boot_code);
      S_RUN:   dest = to_units(vid_code);
      S_DOWN:  dest = 7'd1;
      default: dest = 7'd0;
    endcase
  end

  assign reached = (target_q == dest);
  assign step    = tick_us && !reached && (stp_cnt == SW'(STEP_US - 1));

  always_comb begin
    st_nx = st;
    case (st)
      S_OFF:  if (run_en) st_nx = S_BOOT;
      S_BOOT: if (!run_en) st_nx = S_DOWN;
              else if (reached && tmr >= TW'(CLKEN_DLY_US)) st_nx = S_RUN;
      S_RUN:  if (!run_en) st_nx = S_DOWN;
      S_DOWN: if (target_q <= 7'd1) st_nx = S_OFF;
      default: st_nx = S_OFF;
    endcase
  end

  assign pg_lo_arm = (st == S_RUN) && reached && (tmr >= TW'(PG_DLY_US));
  assign pg_hi_arm = pg_lo_arm && forced_pwm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_OFF;
      target_q <= '0;
      stp_cnt  <= '0;
      tmr      <= '0;
      pg_q     <= 1'b1;
    end else begin
      st <= st_nx;

      if (st_nx == S_OFF)       target_q <= '0;
      else if (step)            target_q <= (target_q < dest) ? target_q + 7'd1 : target_q - 7'd1;

      if (reached || st_nx != st) stp_cnt <= '0;
      else if (tick_us)           stp_cnt <= (stp_cnt == SW'(STEP_US - 1)) ? '0 : stp_cnt + SW'(1);

      if (!reached || st_nx != st)                  tmr <= '0;
      else if (tick_us && tmr < TW'(TMR_MAX))       tmr <= tmr + TW'(1);

      if (st != S_RUN)                pg_q <= 1'b1;
      else if (pg_lo_arm || pg_hi_arm) pg_q <= (pg_lo_arm && !uv_ok) || (pg_hi_arm && !ov_ok);
    end
  end

  assign target    = target_q;
  assign pg_low    = pg_q || !run_en || (st != S_RUN);
  assign clkreq_oe = run_en && (st == S_BOOT || st == S_RUN);
  assign clkreq_lo = clkreq_oe && (st == S_RUN);
  assign all_phase = (st == S_DOWN);
  assign drv_en    = (st != S_OFF);
  assign dischg_on = (st == S_OFF);

  // R3
  step_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_OFF && target_q != $past(target_q)) |-> $past(tick_us));

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_OFF) |-> ({1'b0, target_q} == {1'b0, $past(target_q)} ||
                       {1'b0, target_q} == {1'b0, $past(target_q)} + 8'd1 ||
                       {1'b0, target_q} + 8'd1 == {1'b0, $past(target_q)}));

  // R7
  pg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && !pg_lo_arm && !pg_hi_arm) |=> (!run_en || $stable(pg_low)));

  // R10
  shut_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> (pg_low && !clkreq_oe));

  // R11
  drv_off_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_en) |-> ($past(target_q) <= 7'd1));

  // R2
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> (target_q == 7'd0));

endmodule

// File: tb/test_vid_ramp_seq.sv
module test_vid_ramp_seq;
  localparam int CLK_T = 10;
  localparam int STEP  = 2;
  localparam int CDLY  = 60;
  localparam int PDLY  = 20;

  logic clk = 0, rst_n = 0, tick_us = 0, run_en = 0;
  logic [6:0] vid_code = 7'd90, boot_code = 7'd100;
  logic forced_pwm = 0, uv_ok = 1, ov_ok = 1;
  logic [6:0] target;
  logic clkreq_oe, clkreq_lo, pg_low, pg_lo_arm, pg_hi_arm, all_phase, drv_en, dischg_on;

  int n_chk = 0, n_bad = 0;
  int ticks_seen = 0;
  int tdiv = 0;

  vid_ramp_seq #(.STEP_US(STEP), .CLKEN_DLY_US(CDLY), .PG_DLY_US(PDLY)) i_vid_ramp_seq (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .run_en(run_en),
    .vid_code(vid_code), .boot_code(boot_code), .forced_pwm(forced_pwm),
    .uv_ok(uv_ok), .ov_ok(ov_ok), .target(target), .clkreq_oe(clkreq_oe),
    .clkreq_lo(clkreq_lo), .pg_low(pg_low), .pg_lo_arm(pg_lo_arm),
    .pg_hi_arm(pg_hi_arm), .all_phase(all_phase), .drv_en(drv_en), .dischg_on(dischg_on));

  always #(CLK_T/2) clk = ~clk;

  always @(negedge clk) begin
    tdiv    <= (tdiv == 3) ? 0 : tdiv + 1;
    tick_us <= (tdiv == 3);
  end

  always @(posedge clk) if (tick_us) ticks_seen <= ticks_seen + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic wait_tgt(input int v);
    for (int i = 0; i < 3000 && target != 7'(v); i++) cyc();
  endtask

  task automatic t_reset();
    chk("R2 target", target, 0);
    chk("R2 drv_en", drv_en, 0);
    chk("R2 dischg_on", dischg_on, 1);
    chk("R2 pg_low", pg_low, 1);
    chk("R2 clkreq_oe", clkreq_oe, 0);
    chk("R2 all_phase", all_phase, 0);
  endtask

  task automatic t_startup();
    int prev, last, first, t_reach;
    @(negedge clk); run_en = 1; #1;
    cyc();
    chk("R4 clkreq_oe", clkreq_oe, 1);
    chk("R4 clkreq_lo", clkreq_lo, 0);
    chk("R4 drv_en", drv_en, 1);
    prev = target; first = 1; last = ticks_seen;
    for (int i = 0; i < 3000 && target != 7'd20; i++) begin
      cyc();
      if (target != prev) begin
        chk("R3 step size", target, prev + 1);
        if (!first) chk("R3 step spacing", ticks_seen - last, STEP);
        first = 0; last = ticks_seen; prev = target;
      end
    end
    chk("R4 boot level reached", target, 20);
    t_reach = ticks_seen;
    for (int i = 0; i < 3000 && !clkreq_lo; i++) begin
      cyc();
      if (!clkreq_lo && target != 7'd20) chk("R5 hold at boot", target, 20);
    end
    chk("R5 clkreq delay in window", (ticks_seen - t_reach >= CDLY && ticks_seen - t_reach <= CDLY + 1), 1);
    cyc();
    chk("R7 arms low while slewing", pg_lo_arm | pg_hi_arm, 0);
    wait_tgt(30);
    chk("R1 code 90 destination", target, 30);
    chk("R5 clkreq stays low", clkreq_lo, 1);
  endtask

  task automatic t_pgood();
    int t0 = ticks_seen;
    for (int i = 0; i < 3000 && !pg_lo_arm; i++) cyc();
    chk("R8 lower arm delay in window", (ticks_seen - t0 >= PDLY && ticks_seen - t0 <= PDLY + 1), 1);
    chk("R8 upper arm off outside forced PWM", pg_hi_arm, 0);
    cyc();
    chk("R9 pg released", pg_low, 0);
    @(negedge clk); uv_ok = 0; #1; cyc();
    chk("R9 undervoltage pulls low", pg_low, 1);
    @(negedge clk); uv_ok = 1; #1; cyc();
    chk("R9 recovers", pg_low, 0);
    @(negedge clk); forced_pwm = 1; #1;
    chk("R8 upper arm with forced PWM", pg_hi_arm, 1);
    @(negedge clk); ov_ok = 0; #1; cyc();
    chk("R9 overvoltage pulls low", pg_low, 1);
    @(negedge clk); ov_ok = 1; #1; cyc();
    chk("R9 recovers after ov", pg_low, 0);
  endtask

  task automatic t_retarget();
    int held = 1;
    @(negedge clk); vid_code = 7'd70; #1;
    chk("R7 lower arm dropped", pg_lo_arm, 0);
    chk("R7 upper arm dropped", pg_hi_arm, 0);
    @(negedge clk); uv_ok = 0; #1;
    for (int i = 0; i < 20; i++) begin cyc(); if (pg_low) held = 0; end
    chk("R7 pg held during blank", held, 1);
    wait_tgt(40);
    @(negedge clk); vid_code = 7'd110; uv_ok = 1; #1;
    for (int i = 0; i < 40; i++) cyc();
    chk("R6 reversed direction", (target < 7'd40), 1);
    wait_tgt(10);
    chk("R6 new destination", target, 10);
    @(negedge clk); vid_code = 7'd125; #1;
    wait_tgt(0);
    for (int i = 0; i < 40; i++) cyc();
    chk("R1 clamped code", target, 0);
    @(negedge clk); vid_code = 7'd90; #1;
    wait_tgt(30);
    for (int i = 0; i < 100; i++) cyc();
    chk("R1 back to 30", target, 30);
  endtask

  task automatic t_shutdown();
    int mn = 127;
    @(negedge clk); run_en = 0; #1;
    chk("R10 pg low at once", pg_low, 1);
    chk("R10 clkreq released at once", clkreq_oe, 0);
    cyc();
    chk("R10 all phases", all_phase, 1);
    chk("R10 drivers still on", drv_en, 1);
    for (int i = 0; i < 40; i++) cyc();
    chk("R10 ramping down", (target < 7'd30), 1);
    @(negedge clk); run_en = 1; #1;
    cyc();
    chk("R11 ramp not cut short", all_phase, 1);
    for (int i = 0; i < 3000 && drv_en; i++) begin
      if (target < 7'(mn)) mn = target;
      cyc();
    end
    chk("R11 floor before driver off", mn, 1);
    chk("R11 drivers off", drv_en, 0);
    chk("R11 discharge on", dischg_on, 1);
    chk("R11 target zero", target, 0);
    cyc();
    chk("R4 restart after shutdown", clkreq_oe, 1);
    for (int i = 0; i < 30; i++) cyc();
    @(negedge clk); rst_n = 0; #1; cyc();
    t_reset();
  endtask

  initial begin
    #(CLK_T * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) cyc();
    t_reset();
    @(negedge clk); rst_n = 1; #1;
    cyc();
    t_reset();
    t_startup();
    t_pgood();
    t_retarget();
    t_shutdown();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule